// File: doc/BRIEF.md
# Programmable-Priority Interrupt Arbiter

This block picks one interrupt to offer to a processor out of fifteen sources. Eight of them are external active-low pins. A falling edge on a pin is caught in a pending flag. The other seven are level requests from on-chip peripherals: three timers, a UART receiver, a UART transmitter and two serial-bus controllers. Software gives every source a 3-bit level. Level 0 switches the source off and level 7 is the most urgent. Among the active sources, the one with the highest level wins. Sources on the same level are ranked by a fixed order. The winner is offered to the processor only if its level is above the processor's current mask.

When the processor acknowledges, the block takes a snapshot of the winner and holds it for the whole acknowledge cycle. It then answers in one of two ways. In vector mode it returns the source's 8-bit vector together with a data-acknowledge strobe. In autovector mode it raises an autovector strobe and returns a vector number derived from the level. When the acknowledge ends, the block tells the processor which new mask level to load. With nesting enabled this is the serviced level, so only higher levels can preempt. With nesting disabled it is always 7. The acknowledge also clears the pending flag of an external source. A peripheral request stays active until the peripheral drops it.

Top module: `irq_arbiter`

## Requirements
- R1: A source whose level field is 0 is never offered, even when it is requesting.
- R2: Among requesting sources with a non-zero level, the offered level is the highest such level.
- R3: On equal levels the source with the larger index wins. Source index s is int_req bit s for s = 0..6 (bit 6 timer 2, bit 5 timer 1, bit 4 timer 0, bit 3 UART receive, bit 2 UART transmit, bit 1 serial bus 2, bit 0 serial bus 1) and ext_irq_n bit e for s = 7+e. So external 7 ranks first and serial bus 1 ranks last. The level of source s is src_level[3s+2:3s].
- R4: Outside an acknowledge, irq_level equals the winning level when that level is strictly greater than cpu_mask, and 0 otherwise. It follows the inputs within the same cycle.
- R5: A high-to-low change on ext_irq_n bit e sets that source's pending flag at the next rising clock edge. A steady level and a rising change set nothing.
- R6: A pending flag stays set after its pin returns high, until an acknowledge clears it.
- R7: An acknowledge is captured at the clock edge where ack_req is first seen high. irq_level then shows the captured level (0 if nothing was offered) from the next cycle through the first cycle after ack_req falls, whatever the inputs do.
- R8: If src_autovec bit s of the captured source is 0, then while ack_req stays high after capture, iack_dtack is 1 and iack_vector equals src_vector[8s+7:8s].
- R9: If src_autovec bit s of the captured source is 1, then while ack_req stays high after capture, iack_avec is 1 and iack_vector equals AVEC_BASE (default 0x18) plus the captured level.
- R10: iack_dtack and iack_avec are never high together, and neither is high when ack_req is low. iack_vector is 0 while neither strobe is high.
- R11: In the first cycle ack_req is low after a captured acknowledge, mask_wr pulses for one cycle. With nest_mode 1, mask_val equals the captured level. mask_val is 0 while mask_wr is low.
- R12: With nest_mode 0 at that cycle, mask_val is 7.
- R13: The end of an acknowledge clears the pending flag of a captured external source. An internal request is not affected, and it is offered again as long as its int_req bit is high.
- R14: An acknowledge captured while irq_level was 0 produces no strobe and no mask_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 8 | External active-low interrupt pins, falling-edge latched |
| int_req | input | 7 | Peripheral level requests (bit map in R3) |
| src_level | input | 45 | Per-source 3-bit level, source s at bits 3s+2..3s |
| src_autovec | input | 15 | Per-source answer mode, 1 = autovector |
| src_vector | input | 120 | Per-source 8-bit vector, source s at bits 8s+7..8s |
| nest_mode | input | 1 | 1 = load the serviced level into the mask, 0 = load 7 |
| cpu_mask | input | 3 | Processor's current mask level |
| ack_req | input | 1 | Acknowledge cycle in progress |
| irq_level | output | 3 | Level offered to the processor, 0 = none |
| iack_dtack | output | 1 | Vector-mode acknowledge strobe |
| iack_avec | output | 1 | Autovector strobe |
| iack_vector | output | 8 | Vector or vector number returned in the acknowledge |
| mask_wr | output | 1 | One-cycle pulse asking the processor to load a new mask |
| mask_val | output | 3 | Mask level to load |

## Verification
The bench first runs directed patterns. In the first, only a level-0 source requests, which shows that disabling works. The second raises one timer against several mask values, which shows that the mask comparison is strict. The third drops all eight pins at once with every source on one level, which checks the tie order one acknowledge at a time. Further acknowledges compare vector answers with autovector answers, and nesting with non-nesting mask loads. A level raised in the middle of an acknowledge checks that the snapshot holds. An acknowledge taken under mask 7 checks the spurious case. After that, a long pseudo-random run toggles pins, peripheral requests, levels, masks and acknowledge lengths, including one-cycle acknowledges. A behavioural model checks every output on every cycle, and this separates wrong edge latching, stale pending flags and snapshot slips from arbitration faults.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_OFF = '0;
  localparam lvl_t LVL_MAX = '1;

  // A candidate displaces the running best when it is enabled and at least
  // as urgent; scanning from low to high index makes the larger index win ties.
  function automatic logic takes_slot(input logic cand, input lvl_t cand_lvl,
                                      input logic best_v, input lvl_t best_lvl);
    return cand && (cand_lvl != LVL_OFF) && (!best_v || (cand_lvl >= best_lvl));
  endfunction

  function automatic logic clears_mask(input lvl_t lvl, input lvl_t mask);
    return lvl > mask;
  endfunction

  function automatic lvl_t mask_after_service(input logic nest, input lvl_t lvl);
    return nest ? lvl : LVL_MAX;
  endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
  import irq_arb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  logic [N-1:0] pin_q;
  logic [N-1:0] fall_evt;

  assign fall_evt = pin_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '1;
      pend  <= '0;
    end else begin
      pin_q <= pin_n;
      // a fresh edge wins over a clear in the same cycle
      pend  <= (pend & ~clr) | fall_evt;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R5
    fall_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_n[g]) |=> pend[g]);
    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !clr[g]) |=> pend[g]);
    // R13
    clr_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !fall_evt[g]) |=> !pend[g]);
  end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_arb_pkg::*;
#(
  parameter int N     = 15,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       req,
  input  logic [N*LVL_W-1:0] lvl_flat,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);

  logic [N:0]                  v_ch;
  logic [N:0][LVL_W-1:0]       l_ch;
  logic [N:0][IDX_W-1:0]       i_ch;

  assign v_ch[0] = 1'b0;
  assign l_ch[0] = LVL_OFF;
  assign i_ch[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_stage
    lvl_t my_lvl;
    logic take;
    assign my_lvl     = lvl_flat[g*LVL_W +: LVL_W];
    assign take       = takes_slot(req[g], my_lvl, v_ch[g], l_ch[g]);
    assign v_ch[g+1]  = v_ch[g] | take;
    assign l_ch[g+1]  = take ? my_lvl : l_ch[g];
    assign i_ch[g+1]  = take ? IDX_W'(g) : i_ch[g];
  end

  assign win_valid = v_ch[N];
  assign win_lvl   = l_ch[N];
  assign win_idx   = i_ch[N];

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_arb_pkg::*;
#(
  parameter int               N         = 15,
  parameter int               IDX_W     = $clog2(N),
  parameter int               VEC_W     = 8,
  parameter logic [VEC_W-1:0] AVEC_BASE = 8'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_req,
  input  logic [IDX_W-1:0]   live_idx,
  input  lvl_t               live_lvl,
  input  logic [N-1:0]       src_autovec,
  input  logic [N*VEC_W-1:0] src_vector,
  input  logic               nest_mode,
  output logic               acking,
  output logic [IDX_W-1:0]   frz_idx,
  output lvl_t               frz_lvl,
  output logic               iack_dtack,
  output logic               iack_avec,
  output logic [VEC_W-1:0]   iack_vector,
  output logic               mask_wr,
  output lvl_t               mask_val
);

  function automatic logic [VEC_W-1:0] autovec_num(input lvl_t lvl);
    return AVEC_BASE + VEC_W'(lvl);
  endfunction

  logic             frz_av;
  logic             ack_start;
  logic             ack_end;
  logic             ack_held;
  logic             frz_live;
  logic [VEC_W-1:0] vec_sel;

  assign ack_start = ack_req & ~acking;
  assign ack_end   = acking & ~ack_req;
  assign ack_held  = acking & ack_req;
  assign frz_live  = (frz_lvl != LVL_OFF);
  assign vec_sel   = src_vector[int'(frz_idx)*VEC_W +: VEC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acking  <= 1'b0;
      frz_idx <= '0;
      frz_lvl <= LVL_OFF;
      frz_av  <= 1'b0;
    end else begin
      acking <= ack_req;
      if (ack_start) begin
        frz_idx <= live_idx;
        frz_lvl <= live_lvl;
        frz_av  <= (live_lvl != LVL_OFF) && src_autovec[live_idx];
      end
    end
  end

  assign iack_dtack  = ack_held & frz_live & ~frz_av;
  assign iack_avec   = ack_held & frz_live & frz_av;
  assign iack_vector = iack_avec ? autovec_num(frz_lvl) : (iack_dtack ? vec_sel : '0);
  assign mask_wr     = ack_end & frz_live;
  assign mask_val    = mask_wr ? mask_after_service(nest_mode, frz_lvl) : LVL_OFF;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iack_dtack, iack_avec}) && ((iack_dtack || iack_avec) -> ack_req));
  // R8
  dtack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && live_lvl != LVL_OFF && !src_autovec[live_idx]) |=> (ack_req |-> iack_dtack));
  // R9
  avec_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && live_lvl != LVL_OFF && src_autovec[live_idx])
      |=> (ack_req |-> (iack_avec && iack_vector == AVEC_BASE + VEC_W'($past(live_lvl)))));
  // R14
  spurious_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && live_lvl == LVL_OFF) |=> !(iack_dtack || iack_avec || mask_wr));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int               NUM_EXT   = 8,
  parameter int               NUM_INT   = 7,
  parameter int               VEC_W     = 8,
  parameter logic [VEC_W-1:0] AVEC_BASE = 8'h18
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_EXT-1:0]                 ext_irq_n,
  input  logic [NUM_INT-1:0]                 int_req,
  input  logic [(NUM_EXT+NUM_INT)*LVL_W-1:0] src_level,
  input  logic [NUM_EXT+NUM_INT-1:0]         src_autovec,
  input  logic [(NUM_EXT+NUM_INT)*VEC_W-1:0] src_vector,
  input  logic                               nest_mode,
  input  logic [LVL_W-1:0]                   cpu_mask,
  input  logic                               ack_req,
  output logic [LVL_W-1:0]                   irq_level,
  output logic                               iack_dtack,
  output logic                               iack_avec,
  output logic [VEC_W-1:0]                   iack_vector,
  output logic                               mask_wr,
  output logic [LVL_W-1:0]                   mask_val
);

  localparam int NUM_SRC = NUM_EXT + NUM_INT;
  localparam int IDX_W   = $clog2(NUM_SRC);

  logic [NUM_EXT-1:0] ext_pend;
  logic [NUM_EXT-1:0] ext_clr;
  logic [NUM_SRC-1:0] all_req;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  lvl_t               live_lvl;
  logic               acking;
  logic [IDX_W-1:0]   frz_idx;
  lvl_t               frz_lvl;

  irq_edge_latch #(.N(NUM_EXT)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (ext_irq_n),
    .clr   (ext_clr),
    .pend  (ext_pend)
  );

  // externals sit above internals so they rank first on ties
  assign all_req = {ext_pend, int_req};

  irq_prio_select #(.N(NUM_SRC), .IDX_W(IDX_W)) u_sel (
    .req       (all_req),
    .lvl_flat  (src_level),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign live_lvl = (win_valid && clears_mask(win_lvl, cpu_mask)) ? win_lvl : LVL_OFF;

  irq_ack_ctrl #(
    .N(NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W), .AVEC_BASE(AVEC_BASE)
  ) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_req     (ack_req),
    .live_idx    (win_idx),
    .live_lvl    (live_lvl),
    .src_autovec (src_autovec),
    .src_vector  (src_vector),
    .nest_mode   (nest_mode),
    .acking      (acking),
    .frz_idx     (frz_idx),
    .frz_lvl     (frz_lvl),
    .iack_dtack  (iack_dtack),
    .iack_avec   (iack_avec),
    .iack_vector (iack_vector),
    .mask_wr     (mask_wr),
    .mask_val    (mask_val)
  );

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_clr
    assign ext_clr[e] = mask_wr && (frz_idx == IDX_W'(NUM_INT + e));
  end

  assign irq_level = acking ? frz_lvl : live_lvl;

  // R1
  zero_level_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (src_level[int'(win_idx)*LVL_W +: LVL_W] != LVL_OFF));
  // R4
  offer_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acking && irq_level != LVL_OFF) |-> (irq_level > cpu_mask));
  // R7
  frozen_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acking && $past(acking)) |-> $stable(irq_level));
  // R11
  nest_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && nest_mode) |-> (mask_val == irq_level));
  // R12
  flat_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !nest_mode) |-> (mask_val == LVL_MAX));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_max
    // R2
    no_higher_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acking && all_req[s] && src_level[s*LVL_W +: LVL_W] > cpu_mask)
        |-> (irq_level >= src_level[s*LVL_W +: LVL_W]));
  end

endmodule

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;

  localparam int NE = 8;
  localparam int NI = 7;
  localparam int NS = 15;
  localparam int BASE = 'h18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   ext_irq_n = 8'hff;
  logic [6:0]   int_req = '0;
  logic [44:0]  src_level = '0;
  logic [14:0]  src_autovec = '0;
  logic [119:0] src_vector = '0;
  logic         nest_mode = 1'b1;
  logic [2:0]   cpu_mask = '0;
  logic         ack_req = 1'b0;
  logic [2:0]   irq_level;
  logic         iack_dtack, iack_avec, mask_wr;
  logic [7:0]   iack_vector;
  logic [2:0]   mask_val;

  always #2.5 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .int_req(int_req),
    .src_level(src_level), .src_autovec(src_autovec), .src_vector(src_vector),
    .nest_mode(nest_mode), .cpu_mask(cpu_mask), .ack_req(ack_req),
    .irq_level(irq_level), .iack_dtack(iack_dtack), .iack_avec(iack_avec),
    .iack_vector(iack_vector), .mask_wr(mask_wr), .mask_val(mask_val)
  );

  int  vecs = 0;
  int  bad  = 0;
  bit  done = 0;

  // reference model state
  bit [7:0] m_pend = '0;
  bit [7:0] m_prev = 8'hff;
  bit       m_ack  = 0;
  int       m_fidx = 0;
  int       m_flvl = 0;
  bit       m_fav  = 0;
  int       p_lvl, p_idx;

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl_of(input int s);
    return int'(src_level[s*3 +: 3]);
  endfunction

  task automatic set_lvl(input int s, input int v);
    src_level[s*3 +: 3] = 3'(v);
  endtask

  // search from the top-ranked source down; first strictly higher level sticks
  function automatic void model_offer();
    int best = 0;
    int who  = 0;
    for (int s = NS - 1; s >= 0; s--) begin
      bit act = (s >= NI) ? m_pend[s-NI] : int_req[s];
      if (act && lvl_of(s) > best) begin
        best = lvl_of(s);
        who  = s;
      end
    end
    p_lvl = (best > int'(cpu_mask)) ? best : 0;
    p_idx = who;
  endfunction

  task automatic cycle();
    int  e_lvl, e_vec, e_mv;
    bit  e_dt, e_av, e_mw;
    bit [7:0] n_pend;
    #1;
    model_offer();
    e_lvl = m_ack ? m_flvl : p_lvl;
    e_dt  = m_ack && ack_req && m_flvl != 0 && !m_fav;
    e_av  = m_ack && ack_req && m_flvl != 0 && m_fav;
    e_vec = e_av ? ((BASE + m_flvl) & 255) : (e_dt ? int'(src_vector[m_fidx*8 +: 8]) : 0);
    e_mw  = m_ack && !ack_req && m_flvl != 0;
    e_mv  = e_mw ? (nest_mode ? m_flvl : 7) : 0;
    chk("R1 R2 R3 R4 R5 R6 R7 R13 irq_level", int'(irq_level), e_lvl);
    chk("R8 R10 R14 iack_dtack", int'(iack_dtack), int'(e_dt));
    chk("R9 R10 R14 iack_avec", int'(iack_avec), int'(e_av));
    chk("R3 R8 R9 iack_vector", int'(iack_vector), e_vec);
    chk("R11 R14 mask_wr", int'(mask_wr), int'(e_mw));
    chk("R11 R12 mask_val", int'(mask_val), e_mv);
    for (int e = 0; e < NE; e++)
      n_pend[e] = (m_pend[e] && !(e_mw && m_fidx == NI + e)) || (m_prev[e] && !ext_irq_n[e]);
    @(posedge clk);
    m_pend = n_pend;
    m_prev = ext_irq_n;
    if (ack_req && !m_ack) begin
      m_fidx = p_idx;
      m_flvl = p_lvl;
      m_fav  = (p_lvl != 0) && src_autovec[p_idx];
    end
    m_ack = ack_req;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) src_vector[s*8 +: 8] = 8'(8'h40 + s);
    repeat (3) @(negedge clk);
    #1;
    chk("R4 reset irq_level", int'(irq_level), 0);
    chk("R10 reset strobes", int'({iack_dtack, iack_avec}), 0);
    chk("R11 reset mask_wr", int'(mask_wr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: requesting but disabled
    int_req = 7'h7f;
    #1 chk("R1 disabled sources", int'(irq_level), 0);
    cycle();

    // R4: single timer against masks
    set_lvl(4, 3);
    #1 chk("R4 level above mask 0", int'(irq_level), 3);
    cpu_mask = 3;
    #1 chk("R4 level equal to mask", int'(irq_level), 0);
    cpu_mask = 2;
    cycle();

    // R5 / R6: external 0 at level 6
    set_lvl(7, 6);
    ext_irq_n[0] = 1'b0;
    #1 chk("R5 not before the edge", int'(irq_level), 3);
    cycle();
    chk("R5 edge latched", int'(irq_level), 6);
    ext_irq_n[0] = 1'b1;
    cycle();
    chk("R6 pending held", int'(irq_level), 6);

    // R8 / R11 / R13: vector-mode acknowledge with nesting
    ack_req = 1'b1;
    cycle();
    chk("R8 dtack", int'(iack_dtack), 1);
    chk("R8 vector", int'(iack_vector), 'h47);
    ack_req = 1'b0;
    #1 chk("R11 mask_wr", int'(mask_wr), 1);
    chk("R11 nested mask", int'(mask_val), 6);
    cycle();
    chk("R13 external cleared", int'(irq_level), 3);

    // R9 / R12: autovector, no nesting
    src_autovec[4] = 1'b1;
    ack_req = 1'b1;
    cycle();
    chk("R9 avec", int'(iack_avec), 1);
    chk("R9 vector number", int'(iack_vector), BASE + 3);
    nest_mode = 1'b0;
    ack_req = 1'b0;
    #1 chk("R12 flat mask", int'(mask_val), 7);
    cycle();
    chk("R13 internal stays", int'(irq_level), 3);

    // R3 / R7: all equal, ties by fixed order
    for (int s = 0; s < NS; s++) set_lvl(s, 5);
    src_autovec = '0;
    nest_mode = 1'b1;
    ext_irq_n = 8'h00;
    cycle();
    chk("R2 all level 5", int'(irq_level), 5);
    ack_req = 1'b1;
    cycle();
    chk("R3 external 7 first", int'(iack_vector), 'h4e);
    ack_req = 1'b0;
    cycle();
    ack_req = 1'b1;
    cycle();
    set_lvl(0, 7);
    #1 chk("R7 frozen level", int'(irq_level), 5);
    chk("R3 external 6 next", int'(iack_vector), 'h4d);
    ack_req = 1'b0;
    cycle();
    cycle();

    // R14: acknowledge with nothing offered
    cpu_mask = 7;
    ack_req = 1'b1;
    cycle();
    chk("R14 no strobe", int'({iack_dtack, iack_avec}), 0);
    ack_req = 1'b0;
    #1 chk("R14 no mask write", int'(mask_wr), 0);
    cycle();
    cpu_mask = 0;

    // pseudo-random run against the model
    for (int n = 0; n < 6000; n++) begin
      if (n % 150 == 0) begin
        for (int s = 0; s < NS; s++) set_lvl(s, int'($urandom % 8));
        src_autovec = 15'($urandom);
        nest_mode = 1'($urandom);
      end
      for (int e = 0; e < NE; e++)
        if ($urandom % 8 == 0) ext_irq_n[e] = ~ext_irq_n[e];
      for (int b = 0; b < NI; b++)
        if ($urandom % 16 == 0) int_req[b] = ~int_req[b];
      if ($urandom % 24 == 0) cpu_mask = 3'($urandom);
      if ($urandom % 5 == 0) ack_req = ~ack_req;
      if ($urandom % 200 == 0) set_lvl(int'($urandom % NS), int'($urandom % 8));
      cycle();
    end

    finish_run();
  end

endmodule